// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is the bus-driving end of a two-wire serial link. A host hands it one command at a time: open a transfer, send a byte, receive a byte while acknowledging it, receive a byte without acknowledging it, or close the transfer. The block turns each command into the matching sequence of levels on the clock and data lines. It then reports, for each byte, what came back on the bus.

Both bus lines are open-drain. The block never drives a line high. Each of its two line outputs means "pull this line low", and a released line is read as high through an external pull-up. Each bit is built from four equal quarters of a programmable length in system clocks. SCL is low in the first and last quarters and released in the two middle ones. SDA changes only at the start of a bit, which is the middle of the SCL low time. The host can raise `pause` at any time. The engine then freezes in the next quarter that holds SCL low, for as long as `pause` stays high, and continues without losing any bit. While frozen inside a byte, the engine accepts a close command and abandons that byte.

Commands use a valid/ready handshake. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high when the engine is idle. While the engine is frozen inside a byte, `cmd_ready` is high only if `cmd_op` carries the close code. The response channel also uses valid/ready. Once a byte ends, `rsp_valid` stays high with stable `rsp_data` and `rsp_ack` until `rsp_ready` is seen. No new command is taken while a response is waiting.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset both line outputs are released (0), `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: Command code 0 (open) makes SDA fall while SCL is high and then pulls SCL low. When a transfer is already open, it first releases SDA and then SCL, which gives a repeated open condition.
- R3: Command code 4 (close) pulls SDA low while SCL is low, releases SCL, and then releases SDA while SCL is high. Both lines stay released afterwards. With no transfer open, the close command does nothing.
- R4: Command code 1 (send) puts the 8 bits of `cmd_data` on SDA, most significant bit first. SDA never changes while SCL is released inside a byte.
- R5: On the ninth clock of every byte, `rsp_ack` reports 1 exactly when SDA was low at the mid-point of the SCL high time. During a send, the engine releases SDA for that clock.
- R6: Command codes 2 and 3 (receive) shift 8 bits from SDA into `rsp_data`, most significant bit first. On the ninth clock, code 2 pulls SDA low and code 3 releases it.
- R7: Each SCL high time inside a byte lasts 2*`quarter_len` system clocks. A `quarter_len` of 0 acts as 1.
- R8: While `pause` is 1, the engine holds SCL low at the next quarter where SCL is low. The line outputs do not change until `pause` drops. The byte then finishes with no bit lost or repeated.
- R9: While the engine is frozen inside a byte, a close command is accepted. That byte produces no response. All other commands are refused (`cmd_ready` 0).
- R10: `cmd_ready` is 0 while a sequence is running or a response is waiting. `rsp_valid` with its data and flag stays stable until `rsp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quarter_len | input | QW | System clocks per quarter bit (0 acts as 1) |
| pause | input | 1 | Freeze request; SCL is held low while set |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | 0 open, 1 send, 2 receive+ack, 3 receive+nack, 4 close |
| cmd_data | input | DW | Byte to send |
| rsp_valid | output | 1 | Byte result available |
| rsp_ready | input | 1 | Host takes the result |
| rsp_data | output | DW | Byte received (or sampled) on the bus |
| rsp_ack | output | 1 | Ninth-clock SDA was low |
| scl_drive_low | output | 1 | Pull SCL low |
| sda_drive_low | output | 1 | Pull SDA low |
| sda_in | input | 1 | Sensed SDA level |

## Verification
A wrong quarter counter or bit index shows up on the bus within one bit time. It appears either as an SCL high time other than twice the quarter length, or as a byte that a bus-side observer decodes wrongly or frames with the wrong number of clocks. A wrong freeze condition shows up during a pause: SCL either keeps toggling or is released. A lost or repeated bit shows up as a wrong decoded byte once the pause ends. Errors in the handshake or response state show up in the same cycle as a ready signal that is high while a result is pending, or as a result that changes before it is taken.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    OP_START = 3'd0,
    OP_WRITE = 3'd1,
    OP_RDACK = 3'd2,
    OP_RDNAK = 3'd3,
    OP_STOP  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_BIT   = 3'd2,
    ST_STOP  = 3'd3,
    ST_RESP  = 3'd4
  } st_e;
endpackage

// File: rtl/i2cm_quarter_timer.sv
module i2cm_quarter_timer #(
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hold,
  input  logic [QW-1:0] qlen,
  output logic          tick
);
  logic [QW-1:0] cnt;
  logic [QW:0]   nxt;
  logic          last;

  assign nxt  = {1'b0, cnt} + {{QW{1'b0}}, 1'b1};
  assign last = (nxt >= {1'b0, qlen});
  assign tick = last && !hold && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (!hold)   cnt <= last ? '0 : nxt[QW-1:0];
  end
endmodule

// File: rtl/i2cm_byte_shift.sv
module i2cm_byte_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift,
  input  logic          bit_in,
  output logic          msb,
  output logic [DW-1:0] data
);
  logic [DW-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr <= '0;
    else if (load)   sr <= load_val;
    else if (shift)  sr <= {sr[DW-2:0], bit_in};
  end

  assign msb  = sr[DW-1];
  assign data = sr;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int QW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [QW-1:0] quarter_len,
  input  logic          pause,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_ack,
  output logic          scl_drive_low,
  output logic          sda_drive_low,
  input  logic          sda_in
);
  localparam int IW = $clog2(DW + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(DW);

  st_e          st;
  op_e          op_q;
  logic [1:0]   q;
  logic [IW-1:0] idx;
  logic         bus_act, sda_rest, samp_q, ack_q;
  logic         tick, hold, cmd_fire, msb, bit_drive;
  logic         sh_load, sh_shift;
  logic [DW-1:0] sh_data;
  op_e          cop;

  assign cop = op_e'(cmd_op);

  // freeze only inside a byte, and only in a quarter with SCL low
  assign hold      = pause && (st == ST_BIT) && scl_drive_low;
  assign cmd_ready = (st == ST_IDLE) || (hold && cop == OP_STOP);
  assign cmd_fire  = cmd_valid && cmd_ready;

  i2cm_quarter_timer #(.QW(QW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(cmd_fire), .hold(hold),
    .qlen(quarter_len), .tick(tick)
  );

  assign sh_load  = cmd_fire && (st == ST_IDLE) &&
                    (cop == OP_WRITE || cop == OP_RDACK || cop == OP_RDNAK);
  assign sh_shift = tick && (st == ST_BIT) && (q == 2'd3) && (idx != LAST_IDX);

  i2cm_byte_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load),
    .load_val((cop == OP_WRITE) ? cmd_data : {DW{1'b1}}),
    .shift(sh_shift), .bit_in(samp_q), .msb(msb), .data(sh_data)
  );

  assign bit_drive = (idx == LAST_IDX) ? (op_q == OP_RDACK)
                                       : ((op_q == OP_WRITE) && !msb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; op_q <= OP_START; q <= '0; idx <= '0;
      bus_act <= 1'b0; sda_rest <= 1'b0; samp_q <= 1'b1; ack_q <= 1'b0;
    end else if (st == ST_RESP) begin
      if (rsp_ready) st <= ST_IDLE;
    end else if (cmd_fire) begin
      q <= '0;
      case (cop)
        OP_START: st <= ST_START;
        OP_WRITE, OP_RDACK, OP_RDNAK: begin
          st <= ST_BIT; idx <= '0; op_q <= cop;
        end
        OP_STOP: if (bus_act) st <= ST_STOP;
        default: ;
      endcase
    end else if (tick) begin
      q <= q + 2'd1;
      case (st)
        ST_START: if (q == 2'd3) begin
          st <= ST_IDLE; bus_act <= 1'b1; sda_rest <= 1'b1;
        end
        ST_BIT: begin
          if (q == 2'd1) samp_q <= sda_in;
          if (q == 2'd3) begin
            if (idx == LAST_IDX) begin
              st <= ST_RESP; ack_q <= !samp_q; sda_rest <= bit_drive;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_STOP: if (q == 2'd3) begin
          st <= ST_IDLE; bus_act <= 1'b0; sda_rest <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    scl_drive_low = bus_act;
    sda_drive_low = bus_act && sda_rest;
    case (st)
      ST_START: case (q)
        2'd0:    begin scl_drive_low = bus_act; sda_drive_low = 1'b0; end
        2'd1:    begin scl_drive_low = 1'b0;    sda_drive_low = 1'b0; end
        2'd2:    begin scl_drive_low = 1'b0;    sda_drive_low = 1'b1; end
        default: begin scl_drive_low = 1'b1;    sda_drive_low = 1'b1; end
      endcase
      ST_BIT: begin
        scl_drive_low = (q == 2'd0) || (q == 2'd3);
        sda_drive_low = bit_drive;
      end
      ST_STOP: case (q)
        2'd0:    begin scl_drive_low = 1'b1; sda_drive_low = 1'b1; end
        2'd1:    begin scl_drive_low = 1'b0; sda_drive_low = 1'b1; end
        default: begin scl_drive_low = 1'b0; sda_drive_low = 1'b0; end
      endcase
      default: ;
    endcase
  end

  assign rsp_valid = (st == ST_RESP);
  assign rsp_data  = sh_data;
  assign rsp_ack   = ack_q;

  a_r8_frozen_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !cmd_fire) |=> ($stable(scl_drive_low) && $stable(sda_drive_low)));

  a_r4_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT && !scl_drive_low) |=>
      (st != ST_BIT || scl_drive_low || $stable(sda_drive_low)));

  a_r10_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_data) && $stable(rsp_ack)));

  a_r10_no_cmd_while_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  a_r9_only_stop_midbyte: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && st != ST_IDLE) |-> (cop == OP_STOP));
endmodule

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] qlen = 8'd1;
  logic pause = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_data = 8'd0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic rsp_ack;
  logic scl_drive_low, sda_drive_low;
  logic tgt_pull = 1'b0;
  logic sda_line;

  int checks = 0;
  int errs = 0;

  always #10 clk = ~clk;

  assign sda_line = !sda_drive_low && !tgt_pull;

  i2c_byte_master dut (
    .clk(clk), .rst_n(rst_n), .quarter_len(qlen), .pause(pause),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_ack(rsp_ack), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low), .sda_in(sda_line)
  );

  // bus-side observer and target model
  logic prev_scl = 1'b1, prev_sda = 1'b1, in_frame = 1'b0, bit_clk = 1'b0;
  int bitcnt = 0, hcnt = 0, start_cnt = 0, stop_cnt = 0, byte_cnt = 0;
  logic [7:0] sh = 8'd0, last_byte = 8'd0, rd_val = 8'd0;
  logic nine_low = 1'b0, tgt_read = 1'b0, tgt_ack = 1'b1;
  int qeff;

  always @(negedge clk) begin
    logic scl_l, sda_l;
    scl_l = !scl_drive_low;
    sda_l = sda_line;
    qeff = (qlen == 0) ? 1 : int'(qlen);
    if (prev_scl && scl_l && prev_sda && !sda_l) begin
      start_cnt++; in_frame = 1'b1; bitcnt = 0; bit_clk = 1'b0;
    end else if (prev_scl && scl_l && !prev_sda && sda_l) begin
      stop_cnt++; in_frame = 1'b0; bitcnt = 0; bit_clk = 1'b0;
    end
    if (!prev_scl && scl_l) begin
      hcnt = 1;
      if (in_frame) begin
        bit_clk = 1'b1;
        if (bitcnt < 8) sh = {sh[6:0], sda_l};
        else nine_low = !sda_l;
        bitcnt++;
      end
    end else if (prev_scl && scl_l) begin
      hcnt++;
    end else if (prev_scl && !scl_l) begin
      if (bit_clk) begin
        checks++;
        if (hcnt != 2 * qeff) begin
          errs++;
          $display("FAIL R7: SCL high %0d cycles, expected %0d", hcnt, 2 * qeff);
        end
      end
      bit_clk = 1'b0;
      if (bitcnt == 9) begin byte_cnt++; last_byte = sh; bitcnt = 0; end
    end
    if (!in_frame) tgt_pull = 1'b0;
    else if (!scl_l)
      tgt_pull = tgt_read ? (bitcnt < 8 && !rd_val[7 - bitcnt])
                          : (bitcnt == 8 && tgt_ack);
    prev_scl = scl_l;
    prev_sda = !sda_drive_low && !tgt_pull;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] d);
    @(negedge clk);
    cmd_op = op; cmd_data = d; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_rsp();
    while (!rsp_valid) @(negedge clk);
  endtask

  task automatic wait_ready();
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  initial begin
    int sc, bc, held;
    logic [7:0] v;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(scl_drive_low == 1'b0, "R1 scl", int'(scl_drive_low), 0);
    chk(sda_drive_low == 1'b0, "R1 sda", int'(sda_drive_low), 0);
    chk(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
    chk(rsp_valid == 1'b0, "R1 rsp", int'(rsp_valid), 0);
    rst_n = 1'b1;

    // R3: close with no transfer open is a no-op
    issue(3'd4, 8'd0); wait_ready(); repeat (6) @(negedge clk);
    chk(stop_cnt == 0 && !scl_drive_low, "R3 idle close", stop_cnt, 0);

    // R2 open condition
    issue(3'd0, 8'd0); wait_ready();
    chk(start_cnt == 1, "R2 start", start_cnt, 1);
    chk(scl_drive_low && sda_drive_low, "R2 lines low", int'(scl_drive_low), 1);

    // R4 / R5 send sweep over all byte values at quarter 1
    for (int i = 0; i < 256; i++) begin
      v = 8'(i);
      tgt_ack = v[0];
      issue(3'd1, v);
      if (i == 0) chk(cmd_ready == 1'b0, "R10 busy", int'(cmd_ready), 0);
      wait_rsp();
      chk(last_byte == v, "R4 byte", int'(last_byte), int'(v));
      chk(rsp_ack == v[0], "R5 ack", int'(rsp_ack), int'(v[0]));
    end
    tgt_ack = 1'b1;
    issue(3'd4, 8'd0); wait_ready(); @(negedge clk);
    chk(stop_cnt == 1, "R3 stop", stop_cnt, 1);
    chk(!scl_drive_low && !sda_drive_low, "R3 released", int'(sda_drive_low), 0);

    // R6 receive sweep at quarter 2
    qlen = 8'd2;
    issue(3'd0, 8'd0); wait_ready();
    tgt_read = 1'b1;
    for (int i = 0; i < 256; i++) begin
      v = 8'(255 - i);
      rd_val = v;
      issue(v[0] ? 3'd2 : 3'd3, 8'd0);
      wait_rsp();
      chk(rsp_data == v, "R6 data", int'(rsp_data), int'(v));
      chk(nine_low == v[0], "R6 ninth drive", int'(nine_low), int'(v[0]));
      chk(rsp_ack == v[0], "R5 read ack", int'(rsp_ack), int'(v[0]));
    end
    tgt_read = 1'b0;
    repeat (2) @(negedge clk);
    issue(3'd4, 8'd0); wait_ready();

    // R2 repeated open, then receive
    issue(3'd0, 8'd0); wait_ready();
    issue(3'd1, 8'hA0); wait_rsp();
    sc = start_cnt;
    issue(3'd0, 8'd0); wait_ready();
    chk(start_cnt == sc + 1, "R2 repeated", start_cnt, sc + 1);
    tgt_read = 1'b1; rd_val = 8'h5C;
    issue(3'd3, 8'd0); wait_rsp();
    chk(rsp_data == 8'h5C, "R6 after repeat", int'(rsp_data), 'h5C);
    tgt_read = 1'b0; repeat (2) @(negedge clk);
    issue(3'd4, 8'd0); wait_ready();

    // R7 other quarter lengths, including 0
    foreach (qlen_set[k]) begin
      qlen = qlen_set[k];
      issue(3'd0, 8'd0); wait_ready();
      issue(3'd1, 8'h96); wait_rsp();
      chk(last_byte == 8'h96, "R7 byte", int'(last_byte), 'h96);
      issue(3'd4, 8'd0); wait_ready();
    end

    // R8 pause mid-byte
    qlen = 8'd3;
    issue(3'd0, 8'd0); wait_ready();
    issue(3'd1, 8'hC3);
    while (bitcnt != 3) @(negedge clk);
    pause = 1'b1;
    repeat (20) @(negedge clk);
    bc = bitcnt; held = 1;
    repeat (100) begin
      @(negedge clk);
      if (!scl_drive_low) held = 0;
    end
    chk(held == 1, "R8 scl held", held, 1);
    chk(bitcnt == bc, "R8 no clocks", bitcnt, bc);
    cmd_op = 3'd1; #1;
    chk(cmd_ready == 1'b0, "R9 refuse send", int'(cmd_ready), 0);
    @(negedge clk);
    pause = 1'b0;
    wait_rsp();
    chk(last_byte == 8'hC3, "R8 resumed byte", int'(last_byte), 'hC3);
    chk(rsp_ack == 1'b1, "R8 ack", int'(rsp_ack), 1);

    // R9 close partway through a byte
    issue(3'd1, 8'h3C);
    while (bitcnt != 4) @(negedge clk);
    pause = 1'b1;
    repeat (20) @(negedge clk);
    sc = stop_cnt; bc = byte_cnt; held = 0;
    issue(3'd4, 8'd0);
    pause = 1'b0;
    while (!cmd_ready) begin
      if (rsp_valid) held = 1;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    if (rsp_valid) held = 1;
    chk(stop_cnt == sc + 1, "R9 stop seen", stop_cnt, sc + 1);
    chk(byte_cnt == bc, "R9 no byte", byte_cnt, bc);
    chk(held == 0, "R9 no response", held, 0);
    chk(!scl_drive_low && !sda_drive_low, "R9 released", int'(scl_drive_low), 0);

    // R10 response back-pressure
    issue(3'd0, 8'd0); wait_ready();
    rsp_ready = 1'b0;
    issue(3'd1, 8'h81); wait_rsp();
    v = rsp_data;
    repeat (10) @(negedge clk);
    chk(rsp_valid == 1'b1, "R10 held valid", int'(rsp_valid), 1);
    chk(rsp_data == v, "R10 stable data", int'(rsp_data), int'(v));
    chk(cmd_ready == 1'b0, "R10 no ready", int'(cmd_ready), 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 taken", int'(rsp_valid), 0);
    issue(3'd4, 8'd0); wait_ready();

    report();
  end

  logic [7:0] qlen_set [4] = '{8'd0, 8'd3, 8'd5, 8'd7};
endmodule